// File: doc/BRIEF.md
# Packet-Split Frame Packer and Reassembler

This block moves variable-length messages across a slotted broadcast channel. Each node owns one slot per round. The data field of that slot holds a whole number of equal-sized packets. On the sending side, a table holds one pending message per message id. The id is also the priority, and id 0 is the most urgent. When a slot opens, the packer fills the packets one after another from the most urgent message that still has bytes left. A message that does not fit is cut at a packet boundary and carries on in later slots. Each packet starts with a header cycle that carries the id, a packet index, a last-packet flag and the total message length. After the header come exactly one packet's worth of data bytes. The bytes past the end of a message are zero.

On the receiving side, the reassembler accepts headers and bytes in the same format. It keeps one message in progress per id and passes on only the real payload bytes. It signals a message complete only when every packet of that message has come in, in index order. A packet whose index breaks the sequence throws away the message in progress. The packet size and the number of packets per slot are runtime settings that both sides share. The payload is read from the sender's message store through a combinational read port that gives an id and a byte offset.

Top module: `pkt_frame_xfer`

## Requirements
- R1: After reset, no slot is active (tx_busy low), and no header, data byte, payload output or completion is signalled until a slot_start is given.
- R2: A slot started with packet size P (cfg_pkt_bytes, 0 treated as 1) and budget S (cfg_slot_pkts) sends at most S packets. Every header cycle is followed directly by exactly P data-byte cycles, and the slot ends as soon as the budget is used up or nothing is left to send.
- R3: Each packet is taken from the lowest-numbered id that still has unsent bytes. A partly sent message therefore resumes ahead of any less urgent id in the next slot, but gives way to a more urgent id posted in the meantime.
- R4: The packets of one message carry indices 0, 1, 2, ... in order. The last flag is set only on the packet that holds the final payload byte, and the bytes left over continue in later slots.
- R5: Data bytes past the end of the message inside its final packet are zero. All other data bytes equal the stored payload at offset (bytes already sent + position in packet).
- R6: A post to an id that still has unsent bytes is ignored, and the message already stored is sent whole with its original length. A post of length 0 is ignored.
- R7: The reassembler raises done_valid, with done_id and done_len equal to the message length, on the last byte of the last packet, and only if packets 0..n arrived in order and the count of payload bytes matches the length.
- R8: A header whose index is not the one expected for its id raises rx_drop on that header cycle. This covers a nonzero index with no message in progress, and any index other than the next one while a message is in progress. The message in progress for that id is discarded, so a later packet 0 starts it afresh.
- R9: The reassembler puts out only the first done_len bytes of a message on out_valid/out_byte, in order. Padding bytes and bytes of rejected packets produce no output.
- R10: With two 6-byte messages, P=4 and S=3, the first slot carries the first message as 2 packets and the first 4 bytes of the second. The second slot carries the remaining 2 bytes plus 2 zero pad bytes. With P=3 and S=4, both messages fit in one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pkt_bytes | input | PSZ_W | Packet size in bytes (shared by both sides) |
| cfg_slot_pkts | input | SLOT_W | Packets per slot data field |
| slot_start | input | 1 | Pulse: the node's slot begins (ignored while busy) |
| post_valid | input | 1 | Load a message into the pending table |
| post_id | input | ID_W | Id (and priority) of the posted message |
| post_len | input | LEN_W | Length in bytes of the posted message |
| rd_id | output | ID_W | Payload store read id |
| rd_off | output | LEN_W | Payload store read byte offset |
| rd_byte | input | 8 | Payload byte returned combinationally |
| tx_busy | output | 1 | Slot in progress |
| tx_hdr_valid | output | 1 | Header cycle of an outgoing packet |
| tx_hdr_id | output | ID_W | Outgoing packet message id |
| tx_hdr_idx | output | IDX_W | Outgoing packet index within its message |
| tx_hdr_last | output | 1 | Outgoing packet is the message's final one |
| tx_hdr_len | output | LEN_W | Total length of the outgoing packet's message |
| tx_byte_valid | output | 1 | Outgoing data byte cycle |
| tx_byte | output | 8 | Outgoing data byte |
| rx_hdr_valid | input | 1 | Header cycle of an incoming packet |
| rx_hdr_id | input | ID_W | Incoming packet message id |
| rx_hdr_idx | input | IDX_W | Incoming packet index |
| rx_hdr_last | input | 1 | Incoming packet is final |
| rx_hdr_len | input | LEN_W | Incoming message total length |
| rx_byte_valid | input | 1 | Incoming data byte cycle |
| rx_byte | input | 8 | Incoming data byte |
| out_valid | output | 1 | Reassembled payload byte valid |
| out_id | output | ID_W | Id of the payload byte |
| out_byte | output | 8 | Payload byte |
| done_valid | output | 1 | Message fully received |
| done_id | output | ID_W | Id of the completed message |
| done_len | output | LEN_W | Length of the completed message |
| rx_drop | output | 1 | Incoming header rejected for bad sequence |

## Verification
The assertions assume the incoming side is well formed. Every incoming header is followed by exactly P byte cycles, with no other header in between. The packet size stays fixed while a slot or an incoming packet is in progress. The stimulus keeps to this in two ways. It feeds the packer's output straight back into the reassembler for the table-driven runs. For the sequence-error cases it drives hand-built packets of exactly P bytes, and it changes the configuration only while the block is idle. Messages are kept to at most 16 packets, so the packet index never wraps.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {PK_IDLE, PK_PICK, PK_DATA} pk_state_e;

  // bytes a packet of size psz carries from a message with rem bytes left
  function automatic int f_take(input int rem, input int psz);
    return (rem < psz) ? rem : psz;
  endfunction

  // the packet holding the final byte
  function automatic bit f_fits(input int rem, input int psz);
    return rem <= psz;
  endfunction

  // a zero packet size is read as one byte
  function automatic int f_psz(input int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

endpackage

// File: rtl/pfx_packer.sv
module pfx_packer
  import pfx_pkg::*;
#(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 2,
  parameter int LEN_W   = 6,
  parameter int PSZ_W   = 4,
  parameter int SLOT_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSZ_W-1:0]  cfg_pkt_bytes,
  input  logic [SLOT_W-1:0] cfg_slot_pkts,
  input  logic              slot_start,
  input  logic              post_valid,
  input  logic [ID_W-1:0]   post_id,
  input  logic [LEN_W-1:0]  post_len,
  output logic [ID_W-1:0]   rd_id,
  output logic [LEN_W-1:0]  rd_off,
  input  logic [7:0]        rd_byte,
  output logic              tx_busy,
  output logic              tx_hdr_valid,
  output logic [ID_W-1:0]   tx_hdr_id,
  output logic [IDX_W-1:0]  tx_hdr_idx,
  output logic              tx_hdr_last,
  output logic [LEN_W-1:0]  tx_hdr_len,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte
);

  pk_state_e          state;
  logic [LEN_W-1:0]   e_len [NUM_IDS];
  logic [LEN_W-1:0]   e_off [NUM_IDS];
  logic [IDX_W-1:0]   e_idx [NUM_IDS];
  logic [NUM_IDS-1:0] e_pend;
  logic [PSZ_W-1:0]   psz_q;
  logic [SLOT_W-1:0]  left_q;
  logic [ID_W-1:0]    cur_id;
  logic [PSZ_W-1:0]   byte_cnt;

  logic               any_pend;
  logic [ID_W-1:0]    sel_id;
  logic [LEN_W-1:0]   rem_sel;
  logic [LEN_W-1:0]   rem_cur;
  logic               post_take;
  logic               pkt_end;
  logic               in_msg;

  always_comb begin
    any_pend = 1'b0;
    sel_id   = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (e_pend[i]) begin
        any_pend = 1'b1;
        sel_id   = ID_W'(i);
      end
    end
  end

  assign rem_sel   = e_len[sel_id] - e_off[sel_id];
  assign rem_cur   = e_len[cur_id] - e_off[cur_id];
  assign post_take = post_valid && !e_pend[post_id] && (post_len != '0);
  assign pkt_end   = (state == PK_DATA) && (byte_cnt == psz_q - PSZ_W'(1));
  assign in_msg    = LEN_W'(byte_cnt) < rem_cur;

  assign tx_busy      = (state != PK_IDLE);
  assign tx_hdr_valid = (state == PK_PICK) && any_pend && (left_q != '0);
  assign tx_hdr_id    = sel_id;
  assign tx_hdr_idx   = e_idx[sel_id];
  assign tx_hdr_last  = f_fits(int'(rem_sel), int'(psz_q));
  assign tx_hdr_len   = e_len[sel_id];

  assign rd_id         = cur_id;
  assign rd_off        = e_off[cur_id] + LEN_W'(byte_cnt);
  assign tx_byte_valid = (state == PK_DATA);
  assign tx_byte       = (tx_byte_valid && in_msg) ? rd_byte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PK_IDLE;
      psz_q    <= PSZ_W'(1);
      left_q   <= '0;
      cur_id   <= '0;
      byte_cnt <= '0;
      e_pend   <= '0;
      for (int i = 0; i < NUM_IDS; i++) begin
        e_len[i] <= '0;
        e_off[i] <= '0;
        e_idx[i] <= '0;
      end
    end else begin
      case (state)
        PK_IDLE: begin
          if (slot_start) begin
            psz_q  <= PSZ_W'(f_psz(int'(cfg_pkt_bytes)));
            left_q <= cfg_slot_pkts;
            state  <= PK_PICK;
          end
        end
        PK_PICK: begin
          if (tx_hdr_valid) begin
            cur_id   <= sel_id;
            byte_cnt <= '0;
            state    <= PK_DATA;
          end else begin
            state <= PK_IDLE;
          end
        end
        PK_DATA: begin
          byte_cnt <= byte_cnt + PSZ_W'(1);
          if (pkt_end) begin
            e_off[cur_id] <= e_off[cur_id]
                             + LEN_W'(f_take(int'(rem_cur), int'(psz_q)));
            e_idx[cur_id] <= e_idx[cur_id] + IDX_W'(1);
            if (f_fits(int'(rem_cur), int'(psz_q))) e_pend[cur_id] <= 1'b0;
            left_q <= left_q - SLOT_W'(1);
            state  <= PK_PICK;
          end
        end
        default: state <= PK_IDLE;
      endcase
      // a free entry is never the one being sent, so this cannot collide
      if (post_take) begin
        e_len[post_id]  <= post_len;
        e_off[post_id]  <= '0;
        e_idx[post_id]  <= '0;
        e_pend[post_id] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfx_reasm.sv
module pfx_reasm
  import pfx_pkg::*;
#(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 2,
  parameter int LEN_W   = 6,
  parameter int PSZ_W   = 4,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSZ_W-1:0] cfg_pkt_bytes,
  input  logic             rx_hdr_valid,
  input  logic [ID_W-1:0]  rx_hdr_id,
  input  logic [IDX_W-1:0] rx_hdr_idx,
  input  logic             rx_hdr_last,
  input  logic [LEN_W-1:0] rx_hdr_len,
  input  logic             rx_byte_valid,
  input  logic [7:0]       rx_byte,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id,
  output logic [7:0]       out_byte,
  output logic             done_valid,
  output logic [ID_W-1:0]  done_id,
  output logic [LEN_W-1:0] done_len,
  output logic             rx_drop
);

  logic [NUM_IDS-1:0] act;
  logic [IDX_W-1:0]   exp_idx [NUM_IDS];
  logic [LEN_W-1:0]   got     [NUM_IDS];
  logic [LEN_W-1:0]   mlen    [NUM_IDS];
  logic [ID_W-1:0]    cur_id;
  logic               cur_ok;
  logic               cur_last;
  logic [PSZ_W-1:0]   cnt;
  logic [PSZ_W-1:0]   psz_q;

  logic               hdr_start;
  logic               hdr_cont;
  logic               hdr_ok;
  logic               keep;
  logic               end_pkt;
  logic [LEN_W-1:0]   got_next;

  assign hdr_start = !act[rx_hdr_id] && (rx_hdr_idx == '0);
  assign hdr_cont  = act[rx_hdr_id] && (rx_hdr_idx == exp_idx[rx_hdr_id]);
  assign hdr_ok    = hdr_start || hdr_cont;
  assign rx_drop   = rx_hdr_valid && !hdr_ok;

  assign keep     = rx_byte_valid && cur_ok && (got[cur_id] < mlen[cur_id]);
  assign got_next = got[cur_id] + LEN_W'(keep);
  assign end_pkt  = rx_byte_valid && cur_ok && (cnt == psz_q - PSZ_W'(1));

  assign out_valid  = keep;
  assign out_id     = cur_id;
  assign out_byte   = rx_byte;
  assign done_valid = end_pkt && cur_last && (got_next == mlen[cur_id]);
  assign done_id    = cur_id;
  assign done_len   = mlen[cur_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= '0;
      cur_id   <= '0;
      cur_ok   <= 1'b0;
      cur_last <= 1'b0;
      cnt      <= '0;
      psz_q    <= PSZ_W'(1);
      for (int i = 0; i < NUM_IDS; i++) begin
        exp_idx[i] <= '0;
        got[i]     <= '0;
        mlen[i]    <= '0;
      end
    end else if (rx_hdr_valid) begin
      cur_id   <= rx_hdr_id;
      cur_ok   <= hdr_ok;
      cur_last <= rx_hdr_last;
      cnt      <= '0;
      psz_q    <= PSZ_W'(f_psz(int'(cfg_pkt_bytes)));
      if (hdr_start) begin
        act[rx_hdr_id]     <= 1'b1;
        exp_idx[rx_hdr_id] <= '0;
        got[rx_hdr_id]     <= '0;
        mlen[rx_hdr_id]    <= rx_hdr_len;
      end else if (!hdr_ok) begin
        act[rx_hdr_id] <= 1'b0;
      end
    end else if (rx_byte_valid) begin
      cnt         <= cnt + PSZ_W'(1);
      got[cur_id] <= got_next;
      if (end_pkt) begin
        cur_ok <= 1'b0;
        if (cur_last) act[cur_id] <= 1'b0;
        else          exp_idx[cur_id] <= exp_idx[cur_id] + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/pkt_frame_xfer.sv
module pkt_frame_xfer #(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = $clog2(NUM_IDS),
  parameter int LEN_W   = 6,
  parameter int PSZ_W   = 4,
  parameter int SLOT_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSZ_W-1:0]  cfg_pkt_bytes,
  input  logic [SLOT_W-1:0] cfg_slot_pkts,
  input  logic              slot_start,
  input  logic              post_valid,
  input  logic [ID_W-1:0]   post_id,
  input  logic [LEN_W-1:0]  post_len,
  output logic [ID_W-1:0]   rd_id,
  output logic [LEN_W-1:0]  rd_off,
  input  logic [7:0]        rd_byte,
  output logic              tx_busy,
  output logic              tx_hdr_valid,
  output logic [ID_W-1:0]   tx_hdr_id,
  output logic [IDX_W-1:0]  tx_hdr_idx,
  output logic              tx_hdr_last,
  output logic [LEN_W-1:0]  tx_hdr_len,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte,
  input  logic              rx_hdr_valid,
  input  logic [ID_W-1:0]   rx_hdr_id,
  input  logic [IDX_W-1:0]  rx_hdr_idx,
  input  logic              rx_hdr_last,
  input  logic [LEN_W-1:0]  rx_hdr_len,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [7:0]        out_byte,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [LEN_W-1:0]  done_len,
  output logic              rx_drop
);

  pfx_packer #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .LEN_W(LEN_W),
    .PSZ_W(PSZ_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) packer_i (
    .clk, .rst_n, .cfg_pkt_bytes, .cfg_slot_pkts, .slot_start,
    .post_valid, .post_id, .post_len, .rd_id, .rd_off, .rd_byte,
    .tx_busy, .tx_hdr_valid, .tx_hdr_id, .tx_hdr_idx, .tx_hdr_last,
    .tx_hdr_len, .tx_byte_valid, .tx_byte
  );

  pfx_reasm #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .LEN_W(LEN_W),
    .PSZ_W(PSZ_W), .IDX_W(IDX_W)
  ) reasm_i (
    .clk, .rst_n, .cfg_pkt_bytes, .rx_hdr_valid, .rx_hdr_id, .rx_hdr_idx,
    .rx_hdr_last, .rx_hdr_len, .rx_byte_valid, .rx_byte,
    .out_valid, .out_id, .out_byte, .done_valid, .done_id, .done_len, .rx_drop
  );

endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int LEN_W  = 6,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] cfg_slot_pkts,
  input logic              slot_start,
  input logic              tx_busy,
  input logic              tx_hdr_valid,
  input logic [LEN_W-1:0]  tx_hdr_len,
  input logic              tx_byte_valid,
  input logic [7:0]        tx_byte,
  input logic [LEN_W-1:0]  rd_off,
  input logic              rx_hdr_valid,
  input logic              rx_byte_valid,
  input logic              out_valid,
  input logic              done_valid,
  input logic              rx_drop
);

  logic [SLOT_W-1:0] budget_q;
  logic [SLOT_W:0]   hdr_cnt;
  logic [LEN_W-1:0]  hdr_len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      budget_q  <= '0;
      hdr_cnt   <= '0;
      hdr_len_q <= '0;
    end else begin
      if (slot_start && !tx_busy) begin
        budget_q <= cfg_slot_pkts;
        hdr_cnt  <= '0;
      end else if (tx_hdr_valid) begin
        hdr_cnt <= hdr_cnt + 1'b1;
      end
      if (tx_hdr_valid) hdr_len_q <= tx_hdr_len;
    end
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !slot_start) |=> !tx_busy);

  p_hdr_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hdr_valid |=> tx_byte_valid);

  p_slot_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hdr_valid |-> (hdr_cnt < {1'b0, budget_q}));

  p_hdr_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hdr_valid |-> tx_busy);

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_valid && (rd_off >= hdr_len_q)) |-> (tx_byte == 8'h00));

  p_done_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (rx_byte_valid && !rx_drop));

  p_drop_on_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> (rx_hdr_valid && !out_valid));

  p_out_on_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rx_byte_valid);

endmodule

bind pkt_frame_xfer pfx_checker #(.LEN_W(LEN_W), .SLOT_W(SLOT_W)) chk_i (
  .clk, .rst_n, .cfg_slot_pkts, .slot_start, .tx_busy, .tx_hdr_valid,
  .tx_hdr_len, .tx_byte_valid, .tx_byte, .rd_off, .rx_hdr_valid,
  .rx_byte_valid, .out_valid, .done_valid, .rx_drop
);

// File: tb/pkt_frame_xfer_tb_top.sv
module pkt_frame_xfer_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] cfg_pkt_bytes = 4'd4, cfg_slot_pkts = 4'd1;
  logic slot_start = 1'b0, post_valid = 1'b0;
  logic [1:0] post_id = '0;
  logic [5:0] post_len = '0;
  logic [1:0] rd_id; logic [5:0] rd_off; logic [7:0] rd_byte;
  logic tx_busy, tx_hdr_valid, tx_hdr_last, tx_byte_valid;
  logic [1:0] tx_hdr_id; logic [3:0] tx_hdr_idx; logic [5:0] tx_hdr_len;
  logic [7:0] tx_byte;
  logic rx_hdr_valid, rx_hdr_last, rx_byte_valid;
  logic [1:0] rx_hdr_id; logic [3:0] rx_hdr_idx; logic [5:0] rx_hdr_len;
  logic [7:0] rx_byte;
  logic out_valid, done_valid, rx_drop;
  logic [1:0] out_id, done_id; logic [7:0] out_byte; logic [5:0] done_len;

  logic loop = 1'b1;
  logic m_hv = 1'b0, m_last = 1'b0, m_bv = 1'b0;
  logic [1:0] m_id = '0; logic [3:0] m_idx = '0; logic [5:0] m_len = '0;
  logic [7:0] m_byte = '0;

  function automatic logic [7:0] pat(input int id, input int off);
    return 8'((id * 16 + off + 49) & 255);
  endfunction

  assign rd_byte       = pat(int'(rd_id), int'(rd_off));
  assign rx_hdr_valid  = loop ? tx_hdr_valid  : m_hv;
  assign rx_hdr_id     = loop ? tx_hdr_id     : m_id;
  assign rx_hdr_idx    = loop ? tx_hdr_idx    : m_idx;
  assign rx_hdr_last   = loop ? tx_hdr_last   : m_last;
  assign rx_hdr_len    = loop ? tx_hdr_len    : m_len;
  assign rx_byte_valid = loop ? tx_byte_valid : m_bv;
  assign rx_byte       = loop ? tx_byte       : m_byte;

  pkt_frame_xfer dut_i (.*);

  int total = 0, bad = 0;
  int mrem[4], mlen[4], midx[4], roff[4];
  int mcur = 0, mbyte = 0, P = 4;
  int ndone = 0, nout = 0, slot_pkts = 0, slot_first = -1, last_done_len = -1;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard of the requirements, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (tx_hdr_valid) begin
        int e;
        e = -1;
        for (int i = 3; i >= 0; i--) if (mrem[i] > 0) e = i;
        chk(int'(tx_hdr_id) == e, "R3 header id", int'(tx_hdr_id), e);
        mcur = int'(tx_hdr_id);
        chk(int'(tx_hdr_idx) == midx[mcur], "R4 packet index", int'(tx_hdr_idx), midx[mcur]);
        chk(tx_hdr_last == (mrem[mcur] <= P), "R4 last flag", int'(tx_hdr_last), int'(mrem[mcur] <= P));
        if (slot_pkts == 0) slot_first = mcur;
        slot_pkts++;
        mbyte = 0;
      end
      if (tx_byte_valid) begin
        int eb;
        eb = (mbyte < mrem[mcur]) ? int'(pat(mcur, mlen[mcur] - mrem[mcur] + mbyte)) : 0;
        chk(int'(tx_byte) == eb, "R5 data byte", int'(tx_byte), eb);
        mbyte++;
        if (mbyte == P) begin
          mrem[mcur] = (mrem[mcur] > P) ? mrem[mcur] - P : 0;
          midx[mcur]++;
        end
      end
      if (loop && out_valid) begin
        chk(int'(out_byte) == int'(pat(int'(out_id), roff[out_id])), "R9 payload byte",
            int'(out_byte), int'(pat(int'(out_id), roff[out_id])));
        roff[out_id]++;
        nout++;
      end
      if (loop && done_valid) begin
        chk(int'(done_len) == roff[done_id], "R7 done length", int'(done_len), roff[done_id]);
        last_done_len = int'(done_len);
        roff[done_id] = 0;
        ndone++;
      end
    end
  end

  task automatic post(input int id, input int len);
    @(posedge clk); #1;
    post_valid = 1'b1; post_id = 2'(id); post_len = 6'(len);
    if (mrem[id] == 0 && len != 0) begin
      mrem[id] = len; mlen[id] = len; midx[id] = 0;
    end
    @(posedge clk); #1;
    post_valid = 1'b0;
  endtask

  task automatic run_slot();
    slot_pkts = 0; slot_first = -1;
    @(posedge clk); #1 slot_start = 1'b1;
    @(posedge clk); #1 slot_start = 1'b0;
    forever begin
      @(negedge clk);
      if (!tx_busy) break;
    end
  endtask

  task automatic set_cfg(input int psz, input int spk);
    @(posedge clk); #1;
    cfg_pkt_bytes = 4'(psz); cfg_slot_pkts = 4'(spk); P = psz;
  endtask

  function automatic bit pending();
    return (mrem[0] + mrem[1] + mrem[2] + mrem[3]) > 0;
  endfunction

  // hand-built incoming packet; returns counts of events seen during it
  task automatic send_pkt(input int id, input int idx, input bit last, input int len,
                          input int base, output int outs, output int dones,
                          output int drops, output int dlen);
    outs = 0; dones = 0; drops = 0; dlen = -1;
    @(posedge clk); #1;
    m_hv = 1'b1; m_id = 2'(id); m_idx = 4'(idx); m_last = last; m_len = 6'(len);
    @(negedge clk);
    if (rx_drop) drops++;
    for (int b = 0; b < P; b++) begin
      @(posedge clk); #1;
      m_hv = 1'b0; m_bv = 1'b1;
      m_byte = (base + b < len) ? pat(id, base + b) : 8'h00;
      @(negedge clk);
      if (out_valid) outs++;
      if (done_valid) begin dones++; dlen = int'(done_len); end
    end
    @(posedge clk); #1 m_bv = 1'b0;
  endtask

  // len0 len1 len2 len3 (6b each), packet size, slot packets, packets in first slot
  localparam logic [35:0] VEC [6] = '{
    {6'd6,  6'd6,  6'd0, 6'd0,  4'd4,  4'd3,  4'd3},
    {6'd6,  6'd6,  6'd0, 6'd0,  4'd3,  4'd4,  4'd4},
    {6'd1,  6'd0,  6'd0, 6'd13, 4'd5,  4'd2,  4'd2},
    {6'd0,  6'd20, 6'd7, 6'd0,  4'd8,  4'd15, 4'd4},
    {6'd63, 6'd0,  6'd0, 6'd2,  4'd15, 4'd1,  4'd1},
    {6'd5,  6'd5,  6'd5, 6'd5,  4'd1,  4'd15, 4'd15}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int o, d, dr, dl, nposted, sum, guard;
    for (int i = 0; i < 4; i++) begin mrem[i] = 0; mlen[i] = 0; midx[i] = 0; roff[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_busy && !tx_hdr_valid && !tx_byte_valid, "R1 idle after reset",
        int'(tx_busy) + int'(tx_hdr_valid) + int'(tx_byte_valid), 0);
    chk(!out_valid && !done_valid && !rx_drop, "R1 quiet receiver",
        int'(out_valid) + int'(done_valid) + int'(rx_drop), 0);
    mon_en = 1'b1;

    // table-driven loopback runs (R2, R3, R4, R5, R7, R9, R10)
    for (int r = 0; r < 6; r++) begin
      logic [35:0] v;
      v = VEC[r];
      set_cfg(int'(v[11:8]), int'(v[7:4]));
      nposted = 0; sum = 0; ndone = 0; nout = 0;
      for (int i = 0; i < 4; i++) begin
        int l;
        l = int'(v[35 - 6 * i -: 6]);
        if (l != 0) begin post(i, l); nposted++; sum += l; end
      end
      run_slot();
      chk(slot_pkts == int'(v[3:0]), "R2 packets in first slot", slot_pkts, int'(v[3:0]));
      if (r == 0) chk(ndone == 1, "R10 split across rounds: done after round one", ndone, 1);
      if (r == 1) chk(ndone == 2, "R10 both fit one round", ndone, 2);
      guard = 0;
      while (pending() && guard < 100) begin run_slot(); guard++; end
      if (r == 0) chk(guard == 1 && slot_pkts == 1, "R10 remainder in second round", slot_pkts, 1);
      chk(ndone == nposted, "R7 messages delivered", ndone, nposted);
      chk(nout == sum, "R9 payload byte count", nout, sum);
    end

    // newer urgent message overtakes, split message beats less urgent one (R3)
    set_cfg(4, 1);
    post(2, 10);
    run_slot();
    chk(slot_first == 2, "R3 first slot id", slot_first, 2);
    post(3, 4);
    post(1, 4);
    run_slot();
    chk(slot_first == 1, "R3 urgent overtakes split", slot_first, 1);
    run_slot();
    chk(slot_first == 2, "R3 split resumes before less urgent", slot_first, 2);
    run_slot();
    chk(slot_first == 2, "R4 split final packet", slot_first, 2);
    run_slot();
    chk(slot_first == 3, "R3 least urgent last", slot_first, 3);
    run_slot();
    chk(slot_pkts == 0, "R2 empty slot sends nothing", slot_pkts, 0);

    // repost to a busy id is ignored (R6)
    set_cfg(4, 4);
    post(0, 8);
    post(0, 3);
    post(1, 0);
    run_slot();
    chk(last_done_len == 8, "R6 repost ignored", last_done_len, 8);
    chk(slot_pkts == 2, "R6 zero-length post ignored", slot_pkts, 2);

    // hand-built incoming packets (R7, R8, R9)
    loop = 1'b0;
    set_cfg(4, 1);
    send_pkt(1, 0, 1'b0, 6, 0, o, d, dr, dl);
    chk(o == 4 && d == 0 && dr == 0, "R7 first packet not done", o * 10 + d, 40);
    send_pkt(1, 2, 1'b1, 6, 8, o, d, dr, dl);
    chk(dr == 1 && o == 0 && d == 0, "R8 skipped index dropped", dr * 100 + o * 10 + d, 100);
    send_pkt(1, 1, 1'b1, 6, 4, o, d, dr, dl);
    chk(dr == 1 && d == 0, "R8 message discarded", dr * 10 + d, 10);
    send_pkt(1, 0, 1'b1, 3, 0, o, d, dr, dl);
    chk(o == 3, "R9 padding dropped", o, 3);
    chk(d == 1 && dl == 3, "R7 restart after discard", d * 100 + dl, 103);
    send_pkt(2, 0, 1'b0, 6, 0, o, d, dr, dl);
    chk(d == 0, "R7 not done before last", d, 0);
    send_pkt(2, 1, 1'b1, 6, 4, o, d, dr, dl);
    chk(d == 1 && dl == 6 && o == 2, "R7 in-order completion", d * 100 + dl * 10 + o, 162);
    send_pkt(2, 1, 1'b1, 6, 4, o, d, dr, dl);
    chk(dr == 1 && o == 0, "R8 stale index after completion", dr * 10 + o, 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule